// File: doc/BRIEF.md
# Inferable Jump Classifier

This block sits beside a retirement stream of RV32 instructions, both 32-bit and 16-bit compressed encodings, and tags each indirect jump with whether a trace decoder could work out its target on its own. To do this it keeps a one-bit "holds an upper-immediate constant" flag for every integer register. Upper-immediate writes (LUI, AUIPC and compressed C.LUI) raise the flag of their destination, and any other register write drops it.

When a retired instruction is an indirect jump, the block looks up the flag of its base register as it stood before that instruction. The jump is inferable when the flag is set, and it is always inferable when the base is x0. One cycle after each retire strobe the block presents a valid strobe, an indirect-jump flag and an inferable flag. A trace ingress stage uses these to choose between an inferable and an uninferable jump type. Memory contents, branch outcomes and target arithmetic are not tracked.

Top module: `jump_infer_classifier`

## Requirements
- R1: A retired LUI (opcode 0110111), AUIPC (opcode 0010111) or C.LUI (low bits 01, bits[15:13]=011, rd in bits[11:7] not x0 or x2) sets the constant flag of rd. A compressed word with bits[15:13]=011 in quadrant 01 and rd=x2 is a stack adjust, and it clears the flag of x2.
- R2: Any other retired instruction that writes an integer register clears that register's flag. This covers ADDI, C.LI, C.ADDI, C.MV, register-register ALU operations and loads (opcode 0000011).
- R3: A retired JALR (opcode 1100111, funct3 000, base in bits[19:15]) is reported as indirect. It is inferable exactly when its base register's flag is set.
- R4: C.JR (low bits 10, bits[15:12]=1000, bits[6:2]=0, rs1 in bits[11:7] nonzero) and C.JALR (same with bits[15:12]=1001) are reported as indirect and classified as in R3. C.JALR clears the flag of x1. With rs1=0 these words are not jumps.
- R5: A flag stays set across any number of retired instructions that do not write its register, including stores and branches.
- R6: A jump whose base is x0 is always inferable. Writes to x0 never change any flag.
- R7: When a jump uses the same register as base and link, the classification uses the flag from before the jump, and the flag is then cleared.
- R8: JAL (opcode 1101111), C.J, C.JAL and branches (opcode 1100011) are reported as not indirect. JAL and C.JAL clear the flag of their link register only.
- R9: Reset (rst_ni low, asynchronous) clears every flag and drives all outputs low.
- R10: The outputs are registered. cls_valid_o is high exactly one cycle after retire_valid_i. When cls_valid_o is low, the other outputs are low. Cycles without retire_valid_i leave every flag unchanged. For compressed words, bits[31:16] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| instr_i | input | 32 | Retired instruction word; compressed words use bits[15:0] |
| cls_valid_o | output | 1 | Classification valid, one cycle after retire |
| is_indirect_o | output | 1 | The retired instruction was an indirect jump |
| inferable_o | output | 1 | The indirect jump's target can be inferred |

## Verification
The assertions assume that instr_i carries a legal RV32I or RV32C encoding whenever retire_valid_i is high. Reserved compressed forms are allowed only where R4 and R6 define them. They also assume that a word's low two bits alone decide whether it is compressed. The random stimulus builds each word from a fixed menu of encoders with register fields drawn from x0 to x7. This keeps constant flags and jump bases colliding often. Compressed words carry random upper halves, which exercises the rule that bits[31:16] are ignored.

// File: rtl/jic_pkg.sv
package jic_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_AW  = 5;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef struct packed {
    logic     wr_en;
    reg_idx_t rd;
    logic     set_const;
    logic     is_ind;
    reg_idx_t base;
  } dec_t;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam reg_idx_t LINK_REG = 5'd1;
  localparam reg_idx_t SP_REG   = 5'd2;
endpackage

// File: rtl/jic_dec_full.sv
module jic_dec_full
  import jic_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];

  always_comb begin
    dec_o      = '0;
    dec_o.rd   = instr_i[11:7];
    dec_o.base = instr_i[19:15];
    unique case (opc)
      OPC_LUI, OPC_AUIPC: begin
        dec_o.wr_en     = 1'b1;
        dec_o.set_const = 1'b1;
      end
      OPC_OPIMM, OPC_OP, OPC_LOAD, OPC_AMO, OPC_JAL: dec_o.wr_en = 1'b1;
      OPC_SYSTEM: dec_o.wr_en = (f3 != 3'b000);
      OPC_JALR: begin
        dec_o.wr_en  = (f3 == 3'b000);
        dec_o.is_ind = (f3 == 3'b000);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/jic_dec_comp.sv
module jic_dec_comp
  import jic_pkg::*;
(
  input  logic [15:0] cin_i,
  output dec_t        dec_o
);
  logic [1:0] quad;
  logic [2:0] f3;
  reg_idx_t   rfull;
  reg_idx_t   rs2;
  reg_idx_t   rp_lo;
  reg_idx_t   rp_hi;

  assign quad  = cin_i[1:0];
  assign f3    = cin_i[15:13];
  assign rfull = cin_i[11:7];
  assign rs2   = cin_i[6:2];
  assign rp_lo = {2'b01, cin_i[4:2]};
  assign rp_hi = {2'b01, cin_i[9:7]};

  always_comb begin
    dec_o = '0;
    unique case (quad)
      2'b00: begin
        if (f3 == 3'b000 || f3 == 3'b010) begin
          dec_o.wr_en = 1'b1;
          dec_o.rd    = rp_lo;
        end
      end
      2'b01: begin
        unique case (f3)
          3'b000, 3'b010: begin
            dec_o.wr_en = 1'b1;
            dec_o.rd    = rfull;
          end
          3'b001: begin
            dec_o.wr_en = 1'b1;
            dec_o.rd    = LINK_REG;
          end
          3'b011: begin
            dec_o.wr_en     = 1'b1;
            dec_o.rd        = rfull;
            dec_o.set_const = (rfull != SP_REG);
          end
          3'b100: begin
            dec_o.wr_en = 1'b1;
            dec_o.rd    = rp_hi;
          end
          default: ;
        endcase
      end
      2'b10: begin
        unique case (f3)
          3'b000, 3'b010: begin
            dec_o.wr_en = 1'b1;
            dec_o.rd    = rfull;
          end
          3'b100: begin
            if (rs2 != '0) begin
              dec_o.wr_en = 1'b1;
              dec_o.rd    = rfull;
            end else if (rfull != '0) begin
              dec_o.is_ind = 1'b1;
              dec_o.base   = rfull;
              dec_o.wr_en  = cin_i[12];
              dec_o.rd     = LINK_REG;
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/jic_scoreboard.sv
module jic_scoreboard
  import jic_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_en_i,
  input  reg_idx_t            upd_rd_i,
  input  logic                upd_val_i,
  input  reg_idx_t            base_i,
  output logic                base_known_o,
  output logic [NUM_REGS-1:0] const_o
);
  logic [NUM_REGS-1:0] const_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign const_q[i] = 1'b0;
    end else begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          const_q[i] <= 1'b0;
        end else if (upd_en_i && (upd_rd_i == reg_idx_t'(i))) begin
          const_q[i] <= upd_val_i;
        end
      end
    end
  end

  // pre-update value: read-before-write for base==link
  assign base_known_o = (base_i == '0) || const_q[base_i];
  assign const_o      = const_q;
endmodule

// File: rtl/jic_out_stage.sv
module jic_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic is_ind_i,
  input  logic base_known_i,
  output logic valid_o,
  output logic is_ind_o,
  output logic infer_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      is_ind_o <= 1'b0;
      infer_o  <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      is_ind_o <= valid_i && is_ind_i;
      infer_o  <= valid_i && is_ind_i && base_known_i;
    end
  end
endmodule

// File: rtl/jump_infer_classifier.sv
module jump_infer_classifier
  import jic_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               retire_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               cls_valid_o,
  output logic               is_indirect_o,
  output logic               inferable_o
);
  dec_t dec_full;
  dec_t dec_comp;
  dec_t dec;
  logic base_known;
  logic upd_en;
  logic [NUM_REGS-1:0] const_bits;

  jic_dec_full u_dec_full (
    .instr_i (instr_i),
    .dec_o   (dec_full)
  );

  jic_dec_comp u_dec_comp (
    .cin_i (instr_i[15:0]),
    .dec_o (dec_comp)
  );

  assign dec    = (instr_i[1:0] == 2'b11) ? dec_full : dec_comp;
  assign upd_en = retire_valid_i && dec.wr_en && (dec.rd != '0);

  jic_scoreboard #(
    .NUM_REGS (NUM_REGS)
  ) u_sb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_en_i     (upd_en),
    .upd_rd_i     (dec.rd),
    .upd_val_i    (dec.set_const),
    .base_i       (dec.base),
    .base_known_o (base_known),
    .const_o      (const_bits)
  );

  jic_out_stage u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (retire_valid_i),
    .is_ind_i     (dec.is_ind),
    .base_known_i (base_known),
    .valid_o      (cls_valid_o),
    .is_ind_o     (is_indirect_o),
    .infer_o      (inferable_o)
  );
endmodule

// File: rtl/jic_checker.sv
module jic_checker #(
  parameter int unsigned NUM_REGS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                retire_valid_i,
  input logic [31:0]         instr_i,
  input logic                cls_valid_o,
  input logic                is_indirect_o,
  input logic                inferable_o,
  input logic [NUM_REGS-1:0] const_bits
);
  logic lui_w, opimm_w, jalr_x0_w;
  assign lui_w     = retire_valid_i && instr_i[6:0] == 7'b0110111 && instr_i[11:7] != 5'd0;
  assign opimm_w   = retire_valid_i && instr_i[6:0] == 7'b0010011 && instr_i[11:7] != 5'd0;
  assign jalr_x0_w = retire_valid_i && instr_i[6:0] == 7'b1100111 && instr_i[14:12] == 3'b000
                     && instr_i[19:15] == 5'd0;

  // R10
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i |=> cls_valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |=> (!cls_valid_o && !is_indirect_o && !inferable_o));
  // R10
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |=> $stable(const_bits));
  // R3
  infer_needs_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inferable_o |-> is_indirect_o);
  // R1
  lui_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lui_w |=> const_bits[$past(instr_i[11:7])]);
  // R2
  addi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opimm_w |=> !const_bits[$past(instr_i[11:7])]);
  // R6
  x0_base_infer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jalr_x0_w |=> inferable_o);
endmodule

bind jump_infer_classifier jic_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .retire_valid_i (retire_valid_i),
  .instr_i        (instr_i),
  .cls_valid_o    (cls_valid_o),
  .is_indirect_o  (is_indirect_o),
  .inferable_o    (inferable_o),
  .const_bits     (const_bits)
);

// File: tb/jump_infer_classifier_tb.sv
`timescale 1ns/1ps
module jump_infer_classifier_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        cls_valid_o, is_indirect_o, inferable_o;

  int checks = 0;
  int errs = 0;
  bit cst [32];
  logic  pend_v = 1'b0, pend_ind = 1'b0, pend_inf = 1'b0;
  string pend_tag = "R9";

  always #2.5 clk_i = ~clk_i;

  jump_infer_classifier u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_valid_i (retire_valid_i),
    .instr_i        (instr_i),
    .cls_valid_o    (cls_valid_o),
    .is_indirect_o  (is_indirect_o),
    .inferable_o    (inferable_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_pending();
    chk(pend_tag, "valid", cls_valid_o, pend_v);
    chk(pend_tag, "indirect", is_indirect_o, pend_v & pend_ind);
    chk(pend_tag, "inferable", inferable_o, pend_v & pend_ind & pend_inf);
  endtask

  task automatic issue(input logic v, input logic [31:0] w, input logic ind,
                       input logic inf, input string tag);
    @(negedge clk_i);
    check_pending();
    retire_valid_i = v;
    instr_i        = w;
    pend_v = v; pend_ind = ind; pend_inf = inf; pend_tag = tag;
  endtask

  function automatic void set_c(input int r, input bit v);
    if (r != 0) cst[r] = v;
  endfunction

  function automatic bit known(input int r);
    return (r == 0) || cst[r];
  endfunction

  function automatic logic [31:0] hi16(input logic [15:0] c);
    return {16'($urandom), c};
  endfunction

  // encoders and model updates
  task automatic op_lui(input int rd, input string tag);
    issue(1, {20'($urandom), 5'(rd), 7'b0110111}, 0, 0, tag); set_c(rd, 1);
  endtask
  task automatic op_auipc(input int rd, input string tag);
    issue(1, {20'($urandom), 5'(rd), 7'b0010111}, 0, 0, tag); set_c(rd, 1);
  endtask
  task automatic op_clui(input int rd, input string tag);
    issue(1, hi16({3'b011, 1'b1, 5'(rd), 5'($urandom), 2'b01}), 0, 0, tag);
    set_c(rd, rd != 2);
  endtask
  task automatic op_addi(input int rd, input int rs1, input string tag);
    issue(1, {12'($urandom), 5'(rs1), 3'b000, 5'(rd), 7'b0010011}, 0, 0, tag); set_c(rd, 0);
  endtask
  task automatic op_add(input int rd, input int rs1, input int rs2, input string tag);
    issue(1, {7'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011}, 0, 0, tag); set_c(rd, 0);
  endtask
  task automatic op_lw(input int rd, input int rs1, input string tag);
    issue(1, {12'($urandom), 5'(rs1), 3'b010, 5'(rd), 7'b0000011}, 0, 0, tag); set_c(rd, 0);
  endtask
  task automatic op_sw(input int rs1, input int rs2, input string tag);
    issue(1, {7'b0, 5'(rs2), 5'(rs1), 3'b010, 5'($urandom), 7'b0100011}, 0, 0, tag);
  endtask
  task automatic op_beq(input int rs1, input int rs2, input string tag);
    issue(1, {7'($urandom), 5'(rs2), 5'(rs1), 3'b000, 5'($urandom), 7'b1100011}, 0, 0, tag);
  endtask
  task automatic op_jal(input int rd, input string tag);
    issue(1, {20'($urandom), 5'(rd), 7'b1101111}, 0, 0, tag); set_c(rd, 0);
  endtask
  task automatic op_jalr(input int rd, input int rs1, input string tag);
    issue(1, {12'($urandom), 5'(rs1), 3'b000, 5'(rd), 7'b1100111}, 1, known(rs1), tag);
    set_c(rd, 0);
  endtask
  task automatic op_cjr(input int rs1, input string tag);
    issue(1, hi16({4'b1000, 5'(rs1), 5'b0, 2'b10}), rs1 != 0, known(rs1), tag);
  endtask
  task automatic op_cjalr(input int rs1, input string tag);
    issue(1, hi16({4'b1001, 5'(rs1), 5'b0, 2'b10}), rs1 != 0, known(rs1), tag);
    if (rs1 != 0) set_c(1, 0);
  endtask
  task automatic op_cli(input int rd, input string tag);
    issue(1, hi16({3'b010, 1'b0, 5'(rd), 5'($urandom), 2'b01}), 0, 0, tag); set_c(rd, 0);
  endtask
  task automatic op_cmv(input int rd, input int rs2, input string tag);
    issue(1, hi16({4'b1000, 5'(rd), 5'(rs2), 2'b10}), 0, 0, tag); set_c(rd, 0);
  endtask
  task automatic op_cj(input string tag);
    issue(1, hi16({3'b101, 11'($urandom), 2'b01}), 0, 0, tag);
  endtask
  task automatic op_cjal(input string tag);
    issue(1, hi16({3'b001, 11'($urandom), 2'b01}), 0, 0, tag); set_c(1, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    check_pending();
    rst_ni = 1'b0; retire_valid_i = 1'b0;
    foreach (cst[i]) cst[i] = 0;
    @(negedge clk_i);
    chk("R9", "reset valid", cls_valid_o, 1'b0);
    chk("R9", "reset indirect", is_indirect_o, 1'b0);
    chk("R9", "reset inferable", inferable_o, 1'b0);
    rst_ni = 1'b1;
    pend_v = 0; pend_tag = "R9";
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    checks++; errs++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    foreach (cst[i]) cst[i] = 0;
    repeat (2) @(negedge clk_i);
    chk("R9", "reset valid", cls_valid_o, 1'b0);
    chk("R9", "reset inferable", inferable_o, 1'b0);
    rst_ni = 1'b1;

    op_lui(5, "R1");  op_jalr(0, 5, "R3");
    op_auipc(6, "R1"); op_add(7, 3, 4, "R5"); op_sw(6, 7, "R5"); op_beq(6, 7, "R5");
    op_lw(9, 2, "R5"); op_jalr(1, 6, "R5");
    op_clui(8, "R1"); op_cjr(8, "R4"); op_cjalr(8, "R4"); op_jalr(0, 1, "R4");
    op_addi(9, 0, "R2"); op_jalr(0, 9, "R2");
    op_lui(10, "R2"); op_addi(10, 10, "R2"); op_jalr(0, 10, "R2");
    op_lui(12, "R2"); op_cli(12, "R2"); op_cjr(12, "R2");
    op_lui(13, "R2"); op_cmv(13, 5, "R2"); op_jalr(0, 13, "R2");
    op_lui(14, "R2"); op_lw(14, 3, "R2"); op_cjr(14, "R2");
    op_jalr(0, 0, "R6"); op_lui(0, "R6"); op_jalr(0, 0, "R6"); op_addi(0, 5, "R6");
    op_jalr(0, 5, "R6");
    op_lui(11, "R7"); op_jalr(11, 11, "R7"); op_jalr(0, 11, "R7");
    op_lui(1, "R8"); op_jal(1, "R8"); op_jalr(0, 1, "R8");
    op_lui(1, "R8"); op_cjal("R8"); op_cjr(1, "R8");
    op_lui(15, "R8"); op_jal(0, "R8"); op_beq(15, 0, "R8"); op_cj("R8"); op_jalr(0, 15, "R8");
    op_cjr(0, "R4"); op_cjalr(0, "R4");
    op_lui(2, "R1"); op_clui(2, "R1"); op_jalr(0, 2, "R1");
    op_lui(16, "R10");
    issue(0, {12'h0, 5'd16, 3'b000, 5'd16, 7'b0010011}, 0, 0, "R10");
    issue(0, {12'h0, 5'd16, 3'b000, 5'd0, 7'b1100111}, 0, 0, "R10");
    op_jalr(0, 16, "R10");
    op_lui(17, "R9"); do_reset(); op_jalr(0, 17, "R9");

    for (int n = 0; n < 4000; n++) begin
      int a = int'($urandom % 8);
      int b = int'($urandom % 8);
      case ($urandom % 16)
        0: op_lui(a, "R1");
        1: op_auipc(a, "R1");
        2: op_clui(a, "R1");
        3: op_addi(a, b, "R2");
        4: op_add(a, b, a, "R2");
        5: op_lw(a, b, "R2");
        6: op_sw(a, b, "R5");
        7: op_beq(a, b, "R8");
        8: op_jal(a, "R8");
        9: op_jalr(a, b, "R3");
        10: op_cjr(b, "R4");
        11: op_cjalr(b, "R4");
        12: op_cli(a, "R2");
        13: op_cmv(a, 1 + b % 7, "R2");
        14: op_cj("R8");
        default: issue(0, $urandom, 0, 0, "R10");
      endcase
    end
    issue(0, '0, 0, 0, "R10");
    @(negedge clk_i);
    check_pending();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule